// File: doc/BRIEF.md
# Uncorrectable-Error First-Error and Header Logger

This block records the context of one logged uncorrectable error. When the surrounding error logic decides that an error is to be logged, it pulses a strobe and presents a one-hot status vector naming the error, the four dwords of the offending packet header with a flag saying whether they are valid, and the four dwords of any end-to-end prefix with a flag saying whether a prefix came with the packet. A static input tells the block whether the device advertises end-to-end prefix support.

One clock after the strobe, the block updates three things. It writes the bit position of the error into a 5-bit first-error pointer field of a 32-bit capability/control register. It sets or clears the prefix-log-present flag in that register. It fills or clears two four-dword log arrays. All other bits of the capability register keep their value. Both logs store each dword byte-reversed, so the most significant byte of the log word is the first byte on the wire. Software-side logic reads the capability register directly. It reads the logs through a shared dword index.

Top module: `aer_first_err_logger`

## Requirements
- R1: While reset is asserted, the pointer field (bits 4:0) and the prefix-log-present flag (bit 11) are zero. Every other capability bit equals the CAP_INIT parameter, and all eight log dwords read as zero.
- R2: In the cycle after a strobe, bits 4:0 of the capability register hold the index of the single set bit of the status vector (0 to 31). The status vector must be one-hot whenever the strobe is high.
- R3: If header-valid is high at the strobe, header log dword i afterwards holds input header dword i byte-reversed. Input bits 7:0 move to bits 31:24, and input bits 31:24 move to bits 7:0.
- R4: If header-valid is low at the strobe, all four header log dwords afterwards read zero.
- R5: If both prefix-present and prefix-support are high at the strobe, prefix log dword i afterwards holds input prefix dword i byte-reversed, and bit 11 is set. Prefix-present with header-valid low is an illegal input.
- R6: If prefix-present or prefix-support is low at the strobe, all four prefix log dwords afterwards read zero and bit 11 is cleared.
- R7: A log event leaves every capability bit other than 4:0 and 11 unchanged.
- R8: Without a strobe, changes on the status, header, prefix, flag and support inputs change neither the capability register nor either log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_stb | input | 1 | One-cycle request to log an error |
| err_status | input | 32 | One-hot error status vector |
| hdr_valid | input | 1 | Header dwords are valid |
| hdr_words | input | 128 | Header dwords; dword i is bits 32i+31:32i |
| pfx_present | input | 1 | Packet carried an end-to-end prefix |
| pfx_words | input | 128 | Prefix dwords; dword i is bits 32i+31:32i |
| e2e_pfx_sup | input | 1 | End-to-end prefix support advertised |
| rd_idx | input | 2 | Dword index for log reads |
| cap_reg | output | 32 | Capability/control register |
| hdr_rd_data | output | 32 | Header log dword selected by rd_idx |
| pfx_rd_data | output | 32 | Prefix log dword selected by rd_idx |

## Verification
A single strobe rewrites the pointer field and the prefix-log-present flag of the same register in one cycle, while the untouched bits must keep their value. The bench provokes this with strobes that alternate the prefix decision while the pointer moves between bit 0, bit 31 and interior positions. After each event it compares the whole register against a value built from CAP_INIT, the expected index and the expected flag. Header and prefix capture also fall on the same edge. Each vector therefore mixes the two flags, and all eight dwords are read back at every index before the next event.

// File: rtl/aer_first_err_logger.sv
module aer_first_err_logger #(
  parameter int          STATUS_W = 32,
  parameter int          DW       = 32,
  parameter int          NWORDS   = 4,
  parameter int          PFX_BIT  = 11,
  parameter logic [31:0] CAP_INIT = 32'h0000_03A0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   log_stb,
  input  logic [STATUS_W-1:0]    err_status,
  input  logic                   hdr_valid,
  input  logic [NWORDS*DW-1:0]   hdr_words,
  input  logic                   pfx_present,
  input  logic [NWORDS*DW-1:0]   pfx_words,
  input  logic                   e2e_pfx_sup,
  input  logic [$clog2(NWORDS)-1:0] rd_idx,
  output logic [31:0]            cap_reg,
  output logic [DW-1:0]          hdr_rd_data,
  output logic [DW-1:0]          pfx_rd_data
);
  localparam int PTR_W = $clog2(STATUS_W);
  localparam int NB    = DW / 8;
  localparam logic [31:0] CLR_MASK = ((32'd1 << PTR_W) - 32'd1) | (32'd1 << PFX_BIT);

  function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = d[(NB-1-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] low_bit(input logic [STATUS_W-1:0] s);
    logic [PTR_W-1:0] p;
    p = '0;
    for (int i = STATUS_W-1; i >= 0; i--) if (s[i]) p = PTR_W'(i);
    return p;
  endfunction

  logic [31:0]   cap_q;
  logic [DW-1:0] hdr_q [NWORDS];
  logic [DW-1:0] pfx_q [NWORDS];
  logic          pfx_take;

  assign pfx_take = pfx_present && e2e_pfx_sup;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cap_q <= CAP_INIT & ~CLR_MASK;
    else if (log_stb)
      cap_q <= (cap_q & ~CLR_MASK) | 32'(low_bit(err_status)) | (32'(pfx_take) << PFX_BIT);
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hdr_q[g] <= '0;
        pfx_q[g] <= '0;
      end else if (log_stb) begin
        hdr_q[g] <= hdr_valid ? swap_bytes(hdr_words[g*DW +: DW]) : '0;
        pfx_q[g] <= pfx_take  ? swap_bytes(pfx_words[g*DW +: DW]) : '0;
      end
    end
  end

  assign cap_reg     = cap_q;
  assign hdr_rd_data = hdr_q[rd_idx];
  assign pfx_rd_data = pfx_q[rd_idx];

  // R2
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_stb |-> $countones(err_status) == 1);

  // R2
  ptr_hits_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_stb |=> (($past(err_status) >> cap_reg[PTR_W-1:0]) & 1) == 1);

  // R5
  pfx_needs_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_stb |-> !(pfx_present && !hdr_valid));

  // R5
  pfx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_stb |=> cap_reg[PFX_BIT] == $past(pfx_present && e2e_pfx_sup));

  // R7
  cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cap_reg & ~CLR_MASK) == ($past(cap_reg) & ~CLR_MASK));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !log_stb |=> $stable(cap_reg));
endmodule

// File: tb/tb_aer_first_err_logger.sv
module tb_aer_first_err_logger;
  localparam logic [31:0] CAP_INIT = 32'h0000_03A0;
  localparam logic [31:0] KEEP     = CAP_INIT & ~32'h0000_081F;

  logic clk = 0, rst_n = 0, log_stb = 0, hdr_valid = 0, pfx_present = 0, e2e_pfx_sup = 0;
  logic [31:0] err_status = 32'd1;
  logic [127:0] hdr_words = '0, pfx_words = '0;
  logic [1:0] rd_idx = '0;
  logic [31:0] cap_reg, hdr_rd_data, pfx_rd_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  aer_first_err_logger #(.CAP_INIT(CAP_INIT)) dut (
    .clk(clk), .rst_n(rst_n), .log_stb(log_stb), .err_status(err_status),
    .hdr_valid(hdr_valid), .hdr_words(hdr_words), .pfx_present(pfx_present),
    .pfx_words(pfx_words), .e2e_pfx_sup(e2e_pfx_sup), .rd_idx(rd_idx),
    .cap_reg(cap_reg), .hdr_rd_data(hdr_rd_data), .pfx_rd_data(pfx_rd_data));

  // entry: {bit index[4:0], hdr_valid, pfx_present, support, seed[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {5'd0,  1'b1, 1'b1, 1'b1, 8'hA1},
    {5'd31, 1'b1, 1'b1, 1'b0, 8'h3C},
    {5'd4,  1'b0, 1'b0, 1'b1, 8'h77},
    {5'd17, 1'b1, 1'b0, 1'b1, 8'h5E},
    {5'd9,  1'b1, 1'b1, 1'b1, 8'hC2},
    {5'd22, 1'b0, 1'b0, 1'b0, 8'h08}};

  function automatic logic [31:0] mk(input logic [7:0] seed, input int i, input logic [7:0] kind);
    return {seed, 8'(i * 17 + 3), kind, ~seed};
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_logs(input string rq_h, input string rq_p,
                            input logic [127:0] eh, input logic [127:0] ep);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      chk(rq_h, hdr_rd_data, eh[i*32 +: 32]);
      chk(rq_p, pfx_rd_data, ep[i*32 +: 32]);
    end
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] eh, ep, snap_h, snap_p;
    logic [31:0] snap_c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cap", cap_reg, KEEP);
    check_logs("R1 hdr", "R1 pfx", '0, '0);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      logic [4:0] bi; logic hv, pp, su; logic [7:0] sd;
      {bi, hv, pp, su, sd} = VEC[v];
      @(negedge clk);
      err_status = 32'd1 << bi; hdr_valid = hv; pfx_present = pp; e2e_pfx_sup = su;
      for (int i = 0; i < 4; i++) begin
        hdr_words[i*32 +: 32] = mk(sd, i, 8'h48);
        pfx_words[i*32 +: 32] = mk(sd, i, 8'h50);
      end
      log_stb = 1;
      @(negedge clk);
      log_stb = 0;
      for (int i = 0; i < 4; i++) begin
        eh[i*32 +: 32] = hv ? rev(mk(sd, i, 8'h48)) : 32'h0;
        ep[i*32 +: 32] = (pp && su) ? rev(mk(sd, i, 8'h50)) : 32'h0;
      end
      // R2 pointer, R5/R6 flag, R7 kept bits
      chk(pp && su ? "R2 R5 R7 cap" : "R2 R6 R7 cap", cap_reg,
          KEEP | 32'(bi) | (32'(pp && su) << 11));
      check_logs(hv ? "R3 hdr" : "R4 hdr", (pp && su) ? "R5 pfx" : "R6 pfx", eh, ep);
    end

    // R8: inputs move without a strobe
    snap_c = cap_reg;
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i); #1;
      snap_h[i*32 +: 32] = hdr_rd_data;
      snap_p[i*32 +: 32] = pfx_rd_data;
    end
    @(negedge clk);
    err_status = 32'h0000_0400; hdr_valid = 1; pfx_present = 1; e2e_pfx_sup = 1;
    hdr_words = {4{32'hDEAD_BEEF}}; pfx_words = {4{32'h1234_5678}};
    repeat (3) @(negedge clk);
    chk("R8 cap", cap_reg, snap_c);
    check_logs("R8 hdr", "R8 pfx", snap_h, snap_p);

    // R1 reset after data is held
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 cap", cap_reg, KEEP);
    check_logs("R1 hdr", "R1 pfx", '0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule